// File: doc/BRIEF.md
# Complementary-Challenge Loop Delay Meter

This block runs a loop-type delay PUF and turns it into a signed number. A challenge vector holds one configuration bit per delay element. The block times the oscillating loop twice. The first run uses the challenge as given and the second uses its bitwise complement. It then subtracts the second period count from the first. Each timed run counts reference-clock cycles while the ring completes a programmable number of loops. The loop output is asynchronous, so it passes through a two-flop synchronizer, and the block counts its rising edges.

Each time the challenge driven to the chain changes, the ring is held disabled for a programmable settling interval before it runs again. The subtraction gives the result directly, so no arbiter latch is involved. The counters stop at their ceiling rather than wrapping, and a sticky flag reports that this happened. Software or a sequencer pulses `start`, waits for the single-cycle `done`, and reads `delta`.

Top module: `loop_delta_meter`

## Requirements
- R1: After an accepted start, the first timed run drives `chal_out` with the latched challenge C and the second drives its bitwise complement ~C.
- R2: `chal_out` changes only while `ring_en` is low. After each change, `ring_en` rises exactly `settle`+1 cycles later, so it is low for `settle`+1 consecutive cycles.
- R3: A run's count is the number of reference cycles from the first detected rising loop edge to the N-th rising edge after it, where N is `loops`. The edge input is synchronized through two flops. A `loops` value of 0 acts as 1.
- R4: `delta` is the first count minus the second, as a two's-complement value CNT_W+1 bits wide. It is valid in the cycle `done` is high and holds until the next result.
- R5: `done` is high for exactly one cycle per accepted start.
- R6: `start` is ignored while `busy` is high. A challenge presented then has no effect on `chal_out` or `delta`.
- R7: Counts saturate at 2^CNT_W-1 and never wrap. Reaching that ceiling sets `overflow`, which stays set until the next accepted start clears it.
- R8: After reset, `ring_en`, `done`, `busy` and `overflow` are 0, and `delta` and `chal_out` are all zeros. A reset during a measurement stops the ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a measurement pair (accepted only when idle) |
| challenge | input | N_ELEM | Challenge C, one bit per delay element |
| loops | input | LOOPS_W | Number of loops to time per run (0 acts as 1) |
| settle | input | SETTLE_W | Extra ring-off cycles after each challenge change |
| loop_edge | input | 1 | Asynchronous oscillator output |
| chal_out | output | N_ELEM | Challenge applied to the delay chain |
| ring_en | output | 1 | Enables the oscillating loop |
| delta | output | CNT_W+1 | Signed difference, first count minus second |
| done | output | 1 | One-cycle result-valid pulse |
| overflow | output | 1 | Sticky counter-saturation flag |
| busy | output | 1 | High from an accepted start until done |

## Verification
Some properties can be checked on every cycle, and the assertions cover these:
- the challenge never moves while the ring runs;
- `done` never lasts two cycles;
- the ring stays off whenever the block is idle;
- the period counter never steps backwards within a run;
- `overflow` holds until a start.

Other behaviours need the bench's scenarios, since they depend on a whole measurement:
- the exact settle length;
- the C-then-~C order;
- the arithmetic value of `delta` for several oscillator periods, including the loops=0 case;
- saturation against a known long period;
- a start arriving mid-run having no effect.

// File: rtl/ldm_pkg.sv
// Shared types for the loop delta meter.
package ldm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_RUN    = 2'd2
    } ldm_state_t;
endpackage

// File: rtl/ldm_sync.sv
// Brings an asynchronous level into the clock domain through STAGES flops
// and flags its rising edges with a one-cycle pulse.
// Assumes the input stays high or low for at least two clock cycles.
module ldm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] sh;

    // Shift the input through the synchronizer and one extra history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], async_in};
    end

    // Generate lets a single-stage build still compile when asked for.
    generate
        if (STAGES >= 1) begin : g_edge
            assign rise = sh[STAGES-1] & ~sh[STAGES];
        end
    endgenerate
endmodule

// File: rtl/ldm_period_counter.sv
// Counts reference cycles from the first synchronized rising loop edge to
// the N-th following edge. The count saturates at its ceiling.
// Assumes run stays high for the whole timed run and is low between runs.
module ldm_period_counter #(
    parameter int CNT_W   = 20,
    parameter int LOOPS_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               rise,
    input  logic [LOOPS_W-1:0] loops,
    output logic               finish,
    output logic [CNT_W-1:0]   value,
    output logic               sat
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic               armed;
    logic [CNT_W-1:0]   cnt;
    logic [LOOPS_W-1:0] edges;
    logic [LOOPS_W-1:0] loops_eff;
    logic [CNT_W-1:0]   cnt_inc;

    // Zero loops is treated as one; the increment stops at the ceiling.
    always_comb begin
        loops_eff = (loops == '0) ? LOOPS_W'(1) : loops;
        cnt_inc   = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
        finish    = run && armed && rise &&
                    (({1'b0, edges} + 1'b1) == {1'b0, loops_eff});
        value     = cnt_inc;
        sat       = run && armed && (cnt_inc == CNT_MAX);
    end

    // Arm on the first edge, then count cycles and edges until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            armed <= 1'b0;
            cnt   <= '0;
            edges <= '0;
        end else if (!armed) begin
            if (rise) begin
                armed <= 1'b1;
                cnt   <= '0;
                edges <= '0;
            end
        end else begin
            cnt <= cnt_inc;
            if (rise) edges <= edges + 1'b1;
        end
    end

    // R7: within an armed run the count never decreases (no wrap).
    assert_cnt_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(armed)) |-> (cnt >= $past(cnt)));
endmodule

// File: rtl/ldm_ctrl.sv
// Sequences the measurement pair. It latches the request, drives C, settles,
// times the run, then drives ~C, settles, times again, and subtracts.
// Assumes finish/value/sat come from a counter that is cleared while the ring is off.
module ldm_ctrl
    import ldm_pkg::*;
#(
    parameter int N_ELEM   = 64,
    parameter int CNT_W    = 20,
    parameter int LOOPS_W  = 16,
    parameter int SETTLE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [N_ELEM-1:0]    challenge,
    input  logic [LOOPS_W-1:0]   loops,
    input  logic [SETTLE_W-1:0]  settle,
    input  logic                 finish,
    input  logic [CNT_W-1:0]     value,
    input  logic                 sat,
    output logic [N_ELEM-1:0]    chal_out,
    output logic                 ring_en,
    output logic [LOOPS_W-1:0]   loops_q,
    output logic signed [CNT_W:0] delta,
    output logic                 done,
    output logic                 overflow,
    output logic                 busy
);
    ldm_state_t           state;
    logic                 phase;
    logic [N_ELEM-1:0]    chal_q;
    logic [SETTLE_W-1:0]  settle_q;
    logic [SETTLE_W-1:0]  settle_left;
    logic [CNT_W-1:0]     first_cnt;

    // Busy covers every state except idle.
    always_comb busy = (state != ST_IDLE);

    // Main sequencer: accept, settle, run, swap challenge, repeat, subtract.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            phase       <= 1'b0;
            chal_q      <= '0;
            chal_out    <= '0;
            loops_q     <= '0;
            settle_q    <= '0;
            settle_left <= '0;
            first_cnt   <= '0;
            ring_en     <= 1'b0;
            delta       <= '0;
            done        <= 1'b0;
            overflow    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        chal_q      <= challenge;
                        chal_out    <= challenge;
                        loops_q     <= loops;
                        settle_q    <= settle;
                        settle_left <= settle;
                        phase       <= 1'b0;
                        overflow    <= 1'b0;
                        state       <= ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (settle_left == '0) begin
                        ring_en <= 1'b1;
                        state   <= ST_RUN;
                    end else begin
                        settle_left <= settle_left - 1'b1;
                    end
                end
                ST_RUN: begin
                    if (sat) overflow <= 1'b1;
                    if (finish) begin
                        ring_en <= 1'b0;
                        if (!phase) begin
                            first_cnt   <= value;
                            phase       <= 1'b1;
                            chal_out    <= ~chal_q;
                            settle_left <= settle_q;
                            state       <= ST_SETTLE;
                        end else begin
                            delta <= $signed({1'b0, first_cnt}) - $signed({1'b0, value});
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6: a start seen while busy leaves the latched challenge untouched.
    assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(chal_q));

    // R8: the ring never runs while the sequencer is idle.
    assert_ring_off_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ring_en);
endmodule

// File: rtl/loop_delta_meter.sv
// Top of the loop delta meter: synchronizer, period counter and sequencer.
// Assumes loop_edge comes from a ring that is quiet (low) while ring_en is low.
module loop_delta_meter #(
    parameter int N_ELEM   = 64,
    parameter int CNT_W    = 20,
    parameter int LOOPS_W  = 16,
    parameter int SETTLE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [N_ELEM-1:0]     challenge,
    input  logic [LOOPS_W-1:0]    loops,
    input  logic [SETTLE_W-1:0]   settle,
    input  logic                  loop_edge,
    output logic [N_ELEM-1:0]     chal_out,
    output logic                  ring_en,
    output logic signed [CNT_W:0] delta,
    output logic                  done,
    output logic                  overflow,
    output logic                  busy
);
    logic               rise;
    logic               finish;
    logic               sat;
    logic [CNT_W-1:0]   value;
    logic [LOOPS_W-1:0] loops_q;

    ldm_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (loop_edge),
        .rise     (rise)
    );

    ldm_period_counter #(.CNT_W(CNT_W), .LOOPS_W(LOOPS_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ring_en),
        .rise   (rise),
        .loops  (loops_q),
        .finish (finish),
        .value  (value),
        .sat    (sat)
    );

    ldm_ctrl #(
        .N_ELEM(N_ELEM), .CNT_W(CNT_W), .LOOPS_W(LOOPS_W), .SETTLE_W(SETTLE_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .challenge (challenge),
        .loops     (loops),
        .settle    (settle),
        .finish    (finish),
        .value     (value),
        .sat       (sat),
        .chal_out  (chal_out),
        .ring_en   (ring_en),
        .loops_q   (loops_q),
        .delta     (delta),
        .done      (done),
        .overflow  (overflow),
        .busy      (busy)
    );

    // R2: the challenge seen by the chain only moves with the ring off.
    assert_chal_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chal_out) |-> !ring_en);

    // R5: the result strobe lasts a single cycle.
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: the saturation flag holds until a start arrives.
    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !start) |=> overflow);
endmodule

// File: tb/tb_loop_delta_meter.sv
module tb_loop_delta_meter;
    localparam int N_ELEM = 64;
    localparam int CNT_W  = 10;
    localparam int LW     = 16;
    localparam int SW     = 8;

    typedef struct packed {
        logic [63:0] chal;
        logic [15:0] loops;
        logic [7:0]  settle;
        logic [31:0] exp;
    } vec_t;

    // Period model: half period = 2 + popcount(chal_out[5:0]).
    localparam vec_t VECS [5] = '{
        '{64'h00000000FFFFFFFF, 16'd4, 8'd3, 32'sd48},
        '{64'hFFFFFFFF00000000, 16'd4, 8'd2, -32'sd48},
        '{64'h5A5A5A5A5A5A5A5A, 16'd8, 8'd0, 32'sd0},
        '{64'h0000000000000001, 16'd3, 8'd5, -32'sd24},
        '{64'h0000000000000003, 16'd0, 8'd1, -32'sd4}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [N_ELEM-1:0] challenge = '0;
    logic [LW-1:0] loops = '0;
    logic [SW-1:0] settle = '0;
    logic loop_edge = 1'b0;
    logic [N_ELEM-1:0] chal_out;
    logic ring_en;
    logic signed [CNT_W:0] delta;
    logic done;
    logic overflow;
    logic busy;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    int ph = 0;

    always #2 clk = ~clk;

    loop_delta_meter #(.N_ELEM(N_ELEM), .CNT_W(CNT_W), .LOOPS_W(LW), .SETTLE_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .challenge(challenge),
        .loops(loops), .settle(settle), .loop_edge(loop_edge),
        .chal_out(chal_out), .ring_en(ring_en), .delta(delta),
        .done(done), .overflow(overflow), .busy(busy)
    );

    // Behavioural ring: toggles every half period while enabled, low otherwise.
    always @(negedge clk) begin
        if (!ring_en) begin
            loop_edge <= 1'b0;
            ph <= 0;
        end else if (ph + 1 >= 2 + $countones(chal_out[5:0])) begin
            loop_edge <= ~loop_edge;
            ph <= 0;
        end else begin
            ph <= ph + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One measurement pair, sampled at negedges; optional mid-run start injection.
    task automatic run_pair(input logic [63:0] c, input logic [15:0] n,
                            input logic [7:0] s, input int exp, input bit exp_ovf,
                            input int inject_at, input logic [63:0] alt);
        int low_run = 0;
        int k = 0;
        int cyc = 0;
        int dones = 0;
        bit settle_ok = 1'b1;
        logic [63:0] seen0 = '0;
        logic [63:0] seen1 = '0;
        bit fin = 1'b0;
        @(negedge clk);
        challenge = c; loops = n; settle = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!fin) begin
            if (cyc == inject_at) begin challenge = alt; start = 1'b1; end
            else if (cyc == inject_at + 1) start = 1'b0;
            if (!ring_en) low_run++;
            else if (low_run > 0) begin
                if (low_run != int'(s) + 1) settle_ok = 1'b0;
                if (k == 0) seen0 = chal_out; else seen1 = chal_out;
                k++;
                low_run = 0;
            end
            if (done) begin
                dones++;
                fin = 1'b1;
                chk(int'(delta) == exp, "R4", "delta", int'(delta), exp);
                chk(overflow == exp_ovf, "R7", "overflow at done", overflow, exp_ovf);
            end
            cyc++;
            if (!fin) @(negedge clk);
        end
        start = 1'b0;
        chk(k == 2, "R1", "run count", k, 2);
        chk(seen0 == c, "R1", "first challenge", seen0, c);
        chk(seen1 == ~c, "R1", "second challenge", seen1, ~c);
        chk(settle_ok, "R2", "settle length", settle_ok, 1);
        @(negedge clk);
        chk(done == 1'b0 && dones == 1, "R5", "done pulse", done, 0);
        chk(int'(delta) == exp, "R4", "delta held", int'(delta), exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(!ring_en && !done && !busy && !overflow, "R8", "ctrl outputs", ring_en, 0);
        chk(delta == '0 && chal_out == '0, "R8", "data outputs", delta, 0);
        rst_n = 1'b1;

        // Table of vectors: R1 R2 R3 R4 R5
        for (int i = 0; i < 5; i++)
            run_pair(VECS[i].chal, VECS[i].loops, VECS[i].settle,
                     int'($signed(VECS[i].exp)), 1'b0, -1, '0);

        // R6: start with a different challenge while busy is ignored
        run_pair(64'h00000000FFFFFFFF, 16'd4, 8'd3, 48, 1'b0, 6, 64'h0);

        // R7: long period saturates first count (3200 -> 1023), second 800
        run_pair(64'h000000000000003F, 16'd200, 8'd1, 223, 1'b1, -1, '0);
        repeat (5) @(negedge clk);
        chk(overflow == 1'b1, "R7", "flag sticky", overflow, 1);
        run_pair(64'h00000000FFFFFFFF, 16'd4, 8'd0, 48, 1'b0, -1, '0);

        // R8: reset mid-measurement stops ring
        @(negedge clk);
        challenge = 64'h1; loops = 16'd50; settle = 8'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        chk(ring_en == 1'b1, "R8", "ring running before reset", ring_en, 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!ring_en && !busy && delta == '0, "R8", "after mid-run reset", ring_en, 0);
        rst_n = 1'b1;

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule